// File: doc/BRIEF.md
# Frame Pointer Address Generator

This block forms data-memory addresses for accesses made relative to a stack frame. It keeps a 16-bit base register and an 8-bit offset register. Each frame-pointer access produces the unsigned sum of the base and the zero-extended offset. Software loads either register through a one-cycle register-write port and can read both back at any time.

An access request carries a direction flag and a 2-bit step mode. The step can be none, increment or decrement, and it applies to the offset only. A read uses the offset as it stands and then steps it (post-modify). A write steps the offset first and then uses the stepped value (pre-modify). The offset wraps within its own 8 bits, so a carry or borrow never reaches the base. The address and its valid strobe are registered and appear one clock after the request. The offset update is committed on that same edge.

Top module: `fp_addr_gen`

## Requirements
- R1: After reset, `base_q` is 0000h, `ofs_q` is 00h and `addr_valid` is 0.
- R2: A register write with `reg_sel`=0 loads `reg_wdata[15:0]` into the base. A register write with `reg_sel`=1 loads `reg_wdata[7:0]` into the offset. Both values appear on `base_q`/`ofs_q` after the clock edge.
- R3: For a request in cycle N, `addr_valid` is 1 in cycle N+1. A cycle with no request gives `addr_valid`=0 in the following cycle.
- R4: On a read access (`acc_write`=0), `addr_out` equals base + zero-extended offset, using the offset value held before the access. The offset is then stepped.
- R5: On a write access (`acc_write`=1), the offset is stepped first. `addr_out` equals base + the stepped offset, and the stepped value is stored.
- R6: Offset increments and decrements wrap modulo 256 (FFh+1 gives 00h, 00h-1 gives FFh). The base register is never changed by an access.
- R7: `acc_mode` encoding: 2'b00 leaves the offset unchanged, 2'b01 increments it, 2'b10 decrements it, and 2'b11 is treated as 2'b00.
- R8: A register write to the offset in the same cycle as an access overrides the automatic step. The access address is still formed from the register values held before that edge.
- R9: The 16-bit address sum wraps modulo 65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 base, 1 offset |
| reg_wdata | input | 16 | Register write data |
| base_q | output | 16 | Base register readback |
| ofs_q | output | 8 | Offset register readback |
| acc_req | input | 1 | Frame-pointer access request |
| acc_write | input | 1 | Access direction: 1 write, 0 read |
| acc_mode | input | 2 | Offset step mode |
| addr_out | output | 16 | Registered frame-pointer address |
| addr_valid | output | 1 | Address valid, one clock after request |

## Verification
Directed cases place the offset at 00h and FFh with a base near FFFFh. Run as both reads and writes, they separate post-modify from pre-modify and expose any carry from the offset into the base or any failure of the sum to wrap. Constrained-random cycles then mix register writes, accesses in all four modes and idle cycles, including register writes in the same cycle as an access. This exercises the step-versus-write priority and the reserved mode code. Each cycle is compared against a bench model that tracks both registers.

// File: rtl/fag_pkg.sv
package fag_pkg;
  localparam int unsigned FAG_BASE_W = 16;
  localparam int unsigned FAG_OFS_W  = 8;

  typedef enum logic [1:0] {
    FAG_HOLD = 2'b00,
    FAG_INC  = 2'b01,
    FAG_DEC  = 2'b10,
    FAG_RSVD = 2'b11
  } fag_mode_e;

  localparam logic FAG_SEL_BASE = 1'b0;
  localparam logic FAG_SEL_OFS  = 1'b1;
endpackage

// File: rtl/fag_ofs_step.sv
module fag_ofs_step
  import fag_pkg::*;
#(
  parameter int unsigned OFS_W = FAG_OFS_W
) (
  input  logic [OFS_W-1:0] ofs_cur,
  input  logic [1:0]       mode,
  input  logic             is_write,
  output logic [OFS_W-1:0] ofs_next,
  output logic [OFS_W-1:0] ofs_for_addr,
  output logic             step_active
);
  // Offset arithmetic wraps inside OFS_W bits; nothing leaves this module.
  function automatic logic [OFS_W-1:0] step_ofs(input logic [OFS_W-1:0] v,
                                                input logic [1:0] m);
    case (fag_mode_e'(m))
      FAG_INC: step_ofs = v + OFS_W'(1);
      FAG_DEC: step_ofs = v - OFS_W'(1);
      default: step_ofs = v;             // hold and reserved code (R7)
    endcase
  endfunction

  always_comb begin
    ofs_next     = step_ofs(ofs_cur, mode);
    step_active  = (mode == FAG_INC) || (mode == FAG_DEC);
    // read: post-modify (R4); write: pre-modify (R5)
    ofs_for_addr = is_write ? ofs_next : ofs_cur;
  end

  // R7: reserved and hold codes must not report a step
  always_comb begin
    if (mode == FAG_RSVD || mode == FAG_HOLD)
      a_rsvd_hold_r7: assert (ofs_next == ofs_cur && !step_active);
  end
endmodule

// File: rtl/fag_regs.sv
module fag_regs
  import fag_pkg::*;
#(
  parameter int unsigned BASE_W = FAG_BASE_W,
  parameter int unsigned OFS_W  = FAG_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BASE_W-1:0] wr_data,
  input  logic              auto_en,
  input  logic [OFS_W-1:0]  auto_val,
  output logic [BASE_W-1:0] base_q,
  output logic [OFS_W-1:0]  ofs_q,
  output logic              ofs_wr_hit,
  output logic              base_wr_hit
);
  assign ofs_wr_hit  = wr_en && (wr_sel == FAG_SEL_OFS);
  assign base_wr_hit = wr_en && (wr_sel == FAG_SEL_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_wr_hit) begin
      base_q <= wr_data;
    end
  end

  // Direct write beats the automatic step (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (ofs_wr_hit) begin
      ofs_q <= wr_data[OFS_W-1:0];
    end else if (auto_en) begin
      ofs_q <= auto_val;
    end
  end

  p_base_only_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !base_wr_hit |=> base_q == $past(base_q));

  p_ofs_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_wr_hit |=> ofs_q == $past(wr_data[OFS_W-1:0]));

  p_base_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr_hit |=> base_q == $past(wr_data));
endmodule

// File: rtl/fag_addr_stage.sv
module fag_addr_stage
  import fag_pkg::*;
#(
  parameter int unsigned BASE_W = FAG_BASE_W,
  parameter int unsigned OFS_W  = FAG_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [BASE_W-1:0] base_in,
  input  logic [OFS_W-1:0]  ofs_in,
  output logic [BASE_W-1:0] addr,
  output logic              valid
);
  logic [BASE_W-1:0] ofs_ext;

  generate
    if (OFS_W < BASE_W) begin : g_zext
      assign ofs_ext = {{(BASE_W-OFS_W){1'b0}}, ofs_in};
    end else begin : g_trunc
      assign ofs_ext = ofs_in[BASE_W-1:0];
    end
  endgenerate

  // Unsigned sum, wraps modulo 2**BASE_W (R9)
  function automatic logic [BASE_W-1:0] fp_sum(input logic [BASE_W-1:0] b,
                                               input logic [BASE_W-1:0] o);
    fp_sum = b + o;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= req;
      if (req) addr <= fp_sum(base_in, ofs_ext);
    end
  end

  p_valid_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> valid);

  p_no_req_no_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !valid);

  p_addr_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(addr));
endmodule

// File: rtl/fp_addr_gen.sv
module fp_addr_gen
  import fag_pkg::*;
#(
  parameter int unsigned BASE_W = FAG_BASE_W,
  parameter int unsigned OFS_W  = FAG_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [BASE_W-1:0] reg_wdata,
  output logic [BASE_W-1:0] base_q,
  output logic [OFS_W-1:0]  ofs_q,
  input  logic              acc_req,
  input  logic              acc_write,
  input  logic [1:0]        acc_mode,
  output logic [BASE_W-1:0] addr_out,
  output logic              addr_valid
);
  logic [OFS_W-1:0] ofs_next;
  logic [OFS_W-1:0] ofs_for_addr;
  logic             step_active;
  logic             ofs_wr_hit;
  logic             base_wr_hit;
  logic             auto_commit;

  fag_ofs_step #(.OFS_W(OFS_W)) u_step (
    .ofs_cur      (ofs_q),
    .mode         (acc_mode),
    .is_write     (acc_write),
    .ofs_next     (ofs_next),
    .ofs_for_addr (ofs_for_addr),
    .step_active  (step_active)
  );

  assign auto_commit = acc_req && step_active;

  fag_regs #(.BASE_W(BASE_W), .OFS_W(OFS_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_we),
    .wr_sel      (reg_sel),
    .wr_data     (reg_wdata),
    .auto_en     (auto_commit),
    .auto_val    (ofs_next),
    .base_q      (base_q),
    .ofs_q       (ofs_q),
    .ofs_wr_hit  (ofs_wr_hit),
    .base_wr_hit (base_wr_hit)
  );

  fag_addr_stage #(.BASE_W(BASE_W), .OFS_W(OFS_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (acc_req),
    .base_in (base_q),
    .ofs_in  (ofs_for_addr),
    .addr    (addr_out),
    .valid   (addr_valid)
  );

  p_read_uses_old_ofs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_write |=>
      addr_out == BASE_W'($past(base_q) + BASE_W'($past(ofs_q))));

  p_inc_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_mode == FAG_INC && !ofs_wr_hit |=>
      ofs_q == OFS_W'($past(ofs_q) + OFS_W'(1)));

  p_dec_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_mode == FAG_DEC && !ofs_wr_hit |=>
      ofs_q == OFS_W'($past(ofs_q) - OFS_W'(1)));

  p_rsvd_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_mode == FAG_RSVD && !ofs_wr_hit |=> $stable(ofs_q));

  p_write_uses_new_ofs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_write && !ofs_wr_hit |=>
      addr_out == BASE_W'($past(base_q) + BASE_W'(ofs_q)));
endmodule

// File: tb/fp_addr_gen_test.sv
module fp_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] base_q;
  logic [7:0]  ofs_q;
  logic        acc_req, acc_write;
  logic [1:0]  acc_mode;
  logic [15:0] addr_out;
  logic        addr_valid;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 0;

  // bench model of the two registers
  int unsigned m_base = 0;
  int unsigned m_ofs  = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  fp_addr_gen uut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .base_q(base_q), .ofs_q(ofs_q),
    .acc_req(acc_req), .acc_write(acc_write), .acc_mode(acc_mode),
    .addr_out(addr_out), .addr_valid(addr_valid)
  );

  function automatic int unsigned exp_step(int unsigned o, int unsigned m);
    if (m == 1) return (o + 1) % 256;
    if (m == 2) return (o + 255) % 256;
    return o;
  endfunction

  function automatic int unsigned exp_addr(int unsigned b, int unsigned o);
    return (b + o) % 65536;
  endfunction

  task automatic check(string tag, string what, int unsigned got, int unsigned exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // Drive at negedge, let one posedge pass, compare at next negedge.
  task automatic cyc(bit we, bit sel, int unsigned wd, bit req, bit wr,
                     int unsigned mode, string tag);
    int unsigned stepped, e_addr, n_base, n_ofs;
    reg_we = we; reg_sel = sel; reg_wdata = 16'(wd);
    acc_req = req; acc_write = wr; acc_mode = 2'(mode);
    stepped = exp_step(m_ofs, mode);
    e_addr  = exp_addr(m_base, wr ? stepped : m_ofs);
    n_base  = m_base;
    n_ofs   = m_ofs;
    if (we && !sel) n_base = wd % 65536;
    if (we && sel) n_ofs = wd % 256;
    else if (req)  n_ofs = stepped;
    @(posedge clk);
    @(negedge clk);
    m_base = n_base;
    m_ofs  = n_ofs;
    check(tag, "valid", addr_valid, req);
    if (req) check(tag, "addr", addr_out, e_addr);
    check(tag, "base", base_q, m_base);
    check(tag, "ofs", ofs_q, m_ofs);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd7741));
    rst_n = 1'b0;
    reg_we = 0; reg_sel = 0; reg_wdata = 0;
    acc_req = 0; acc_write = 0; acc_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "base", base_q, 0);
    check("R1", "ofs", ofs_q, 0);
    check("R1", "valid", addr_valid, 0);

    // R2 loads
    cyc(1, 0, 16'hFFF0, 0, 0, 0, "R2");
    cyc(1, 1, 16'hABFF, 0, 0, 0, "R2");
    // R4 read post-increment from FF: addr uses FF, ofs wraps to 00 (R6)
    cyc(0, 0, 0, 1, 0, 1, "R4");
    // R9 sum wrap: base FFF0 + ofs read at 00 -> FFF0; write pre-dec -> FF -> 00EF
    cyc(0, 0, 0, 1, 1, 2, "R5");
    cyc(1, 0, 16'hFFFF, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, 0, 0, "R9");
    // R6 write pre-increment FF -> 00, base untouched
    cyc(0, 0, 0, 1, 1, 1, "R6");
    // R6 read post-decrement 00 -> FF
    cyc(0, 0, 0, 1, 0, 2, "R6");
    // R7 reserved code holds the offset
    cyc(0, 0, 0, 1, 1, 3, "R7");
    cyc(0, 0, 0, 1, 0, 3, "R7");
    // R8 direct write beats step, address from old values
    cyc(1, 1, 16'h0042, 1, 1, 1, "R8");
    cyc(1, 1, 16'h0010, 1, 0, 2, "R8");
    // R3 idle gives no valid
    cyc(0, 0, 0, 0, 0, 1, "R3");

    for (int i = 0; i < 600; i++) begin
      bit we, sel, req, wr;
      int unsigned wd, md;
      we  = ($urandom % 4) == 0;
      sel = $urandom % 2;
      wd  = $urandom % 65536;
      req = ($urandom % 4) != 0;
      wr  = $urandom % 2;
      md  = $urandom % 4;
      cyc(we, sel, wd, req, wr, md,
          (we && sel && req) ? "R8" : (md == 3 ? "R7" : (wr ? "R5" : "R4")));
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule